// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break and Preamble Insertion

This block serialises 8-bit words onto a single asynchronous line. Software writes a byte into a holding register. At the next free bit boundary the byte moves into a shift register and goes out as a ten-bit frame. Bit boundaries come from an external baud strobe that pulses once per bit time. Two status flags report progress: one says the holding register is empty, the other says the line has gone quiet. Each flag has an interrupt enable, and the enabled flags are combined into one registered interrupt line.

Two control bits can place special frames between data words. Pulsing the transmit enable low and then high while a frame is on the line queues a preamble, which is one frame of all mark bits. Setting and then clearing the break bit queues one break frame, which is all space bits. While the break bit stays set, break frames repeat and data waits. Turning the enable on from idle first holds the line at mark for one bit time.

Top module: `async_tx_framer`

## Requirements
- R1: After synchronous reset the line is high (mark), the holding-empty flag is 1, the line-quiet flag is 0 and the interrupt is 0.
- R2: A data frame is a 0 start bit, then the 8 data bits least-significant first, then a 1 stop bit. Every bit starts on a baud strobe and lasts until the next strobe.
- R3: While the enable is 0, no new frame starts and the line stays high. A frame already on the line still completes.
- R4: When the enable rises while no frame is on the line, the line stays high for one full bit time before the first start bit.
- R5: When the enable goes 0 and then back to 1 while a frame is on the line, that frame completes. A preamble of ten 1 bits follows, and only then any pending data.
- R6: While the break bit is 1 and the enable is 1, back-to-back break frames of ten 0 bits are sent, and data in the holding register waits.
- R7: When the break bit goes from 1 to 0, exactly one more break frame is sent after the current frame.
- R8: When both a queued break and a queued preamble are pending at a frame boundary, the break goes first and the preamble second.
- R9: The holding-empty flag is set when the holding register moves into the shift register and is cleared by a data write. A write in the same cycle as the move takes precedence.
- R10: The line-quiet flag is set at the strobe where a frame ends with nothing to follow it, and is cleared when any frame starts.
- R11: The interrupt equals (holding-empty AND its enable) OR (line-quiet AND its enable), sampled one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe per bit time |
| tx_en | input | 1 | Transmitter enable control bit |
| brk_req | input | 1 | Send-break control bit |
| dr_wr | input | 1 | Write strobe for the data register |
| dr_wdata | input | 8 | Byte written to the holding register |
| ie_empty | input | 1 | Interrupt enable for the holding-empty flag |
| ie_done | input | 1 | Interrupt enable for the line-quiet flag |
| txd | output | 1 | Serial line, idles high |
| tx_empty | output | 1 | Holding register empty flag |
| tx_done | output | 1 | Line-quiet (transmission complete) flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets the places where control-bit edges meet frame boundaries. It lowers the enable mid-frame and holds it low: a design that aborted the frame would cut the stop bit short. It also pulses the enable mid-frame, where a design that ignored the pulse would omit the ten-mark preamble, and it enables from idle, where a design that sent at once would put the start bit a bit time too early. Break tests check that a held break repeats and that release yields exactly one extra break, not zero and not two. They also check that a break and a preamble queued together come out break first. A design that got any of these wrong would move the line or the flags off the cycles the reference model predicts.

// File: rtl/txf_pkg.sv
package txf_pkg;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_GUARD = 3'd1,
        K_BREAK = 3'd2,
        K_PRE   = 3'd3,
        K_DATA  = 3'd4
    } kind_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   len;
        kind_e              kind;
    } frame_t;

    // Bit 0 of bits is sent first.
    function automatic frame_t make_frame(kind_e k, logic [DATA_W-1:0] d);
        frame_t f;
        f.kind = k;
        case (k)
            K_GUARD: begin f.bits = '1; f.len = CNT_W'(1); end
            K_BREAK: begin f.bits = '0; f.len = CNT_W'(FRAME_W); end
            K_PRE:   begin f.bits = '1; f.len = CNT_W'(FRAME_W); end
            K_DATA:  begin f.bits = {1'b1, d, 1'b0}; f.len = CNT_W'(FRAME_W); end
            default: begin f.bits = '1; f.len = '0; end
        endcase
        return f;
    endfunction
endpackage

// File: rtl/txf_shifter.sv
module txf_shifter
    import txf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] ld_bits,
    input  logic [CNT_W-1:0]   ld_len,
    output logic               txd,
    output logic               ready,
    output logic               active,
    output logic               frame_end
);
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   cnt;

    assign ready     = (cnt == '0);
    assign frame_end = tick && ready && active && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '1;
            cnt    <= '0;
            txd    <= 1'b1;
            active <= 1'b0;
        end else if (tick) begin
            if (!ready) begin
                txd <= sh[0];
                sh  <= {1'b1, sh[FRAME_W-1:1]};
                cnt <= cnt - CNT_W'(1);
            end else if (load) begin
                txd    <= ld_bits[0];
                sh     <= {1'b1, ld_bits[FRAME_W-1:1]};
                cnt    <= ld_len - CNT_W'(1);
                active <= 1'b1;
            end else begin
                txd    <= 1'b1;
                active <= 1'b0;
            end
        end
    end

    // R3: with no frame on the line the output rests at mark
    assert_idle_mark_R3: assert property (@(posedge clk) disable iff (rst)
        !active |-> txd);
    // R2: the bit counter never exceeds one frame
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(FRAME_W));
endmodule

// File: rtl/txf_sequencer.sv
module txf_sequencer
    import txf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               ready,
    input  logic               active,
    input  logic               en,
    input  logic               brk,
    input  logic               tdre,
    input  logic [DATA_W-1:0]  hold,
    output logic               load,
    output logic               take_data,
    output logic [FRAME_W-1:0] ld_bits,
    output logic [CNT_W-1:0]   ld_len
);
    logic  en_q, brk_q;
    logic  pend_guard, pend_brk, pend_pre;
    kind_e pick;
    frame_t frm;

    always_comb begin
        pick = K_NONE;
        if (en) begin
            if (pend_guard)    pick = K_GUARD;
            else if (pend_brk) pick = K_BREAK;
            else if (pend_pre) pick = K_PRE;
            else if (brk)      pick = K_BREAK;
            else if (!tdre)    pick = K_DATA;
        end
    end

    assign load      = tick && ready && (pick != K_NONE);
    assign take_data = load && (pick == K_DATA);
    assign frm       = make_frame(pick, hold);
    assign ld_bits   = frm.bits;
    assign ld_len    = frm.len;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            brk_q      <= 1'b0;
            pend_guard <= 1'b0;
            pend_brk   <= 1'b0;
            pend_pre   <= 1'b0;
        end else begin
            en_q  <= en;
            brk_q <= brk;
            if (load && pick == K_GUARD) pend_guard <= 1'b0;
            if (load && pick == K_BREAK) pend_brk   <= 1'b0;
            if (load && pick == K_PRE)   pend_pre   <= 1'b0;
            if (en && !en_q) begin
                if (active) pend_pre   <= 1'b1;
                else        pend_guard <= 1'b1;
            end
            if (!brk && brk_q) pend_brk <= 1'b1;
        end
    end

    // R9: data is only taken from a full holding register
    assert_take_full_R9: assert property (@(posedge clk) disable iff (rst)
        take_data |-> !tdre);
    // R6: no data frame starts while a break is requested or queued
    assert_brk_blocks_data_R6: assert property (@(posedge clk) disable iff (rst)
        take_data |-> (!brk && !pend_brk));
    // R2: frames start only at a bit boundary with the shifter free
    assert_load_on_boundary_R2: assert property (@(posedge clk) disable iff (rst)
        load |-> (tick && ready));
endmodule

// File: rtl/txf_flags.sv
module txf_flags
    import txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take_data,
    input  logic              load,
    input  logic              frame_end,
    input  logic              ie_empty,
    input  logic              ie_done,
    output logic [DATA_W-1:0] hold,
    output logic              tdre,
    output logic              tc,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            tdre <= 1'b1;
            tc   <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (take_data) tdre <= 1'b1;
            if (wr) begin
                hold <= wdata;
                tdre <= 1'b0;
            end
            if (load)           tc <= 1'b0;
            else if (frame_end) tc <= 1'b1;
            irq <= (ie_empty && tdre) || (ie_done && tc);
        end
    end

    // R9: a write always leaves the holding register full
    assert_wr_fills_R9: assert property (@(posedge clk) disable iff (rst)
        wr |=> !tdre);
    // R10: a frame ending with nothing behind it raises the quiet flag
    assert_end_sets_tc_R10: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> tc);
    // R10: any frame start clears the quiet flag
    assert_load_clears_tc_R10: assert property (@(posedge clk) disable iff (rst)
        load |=> !tc);
    // R11: with both enables off no request appears
    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
        !(ie_empty || ie_done) |=> !irq);
endmodule

// File: rtl/async_tx_framer.sv
module async_tx_framer
    import txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              dr_wr,
    input  logic [DATA_W-1:0] dr_wdata,
    input  logic              ie_empty,
    input  logic              ie_done,
    output logic              txd,
    output logic              tx_empty,
    output logic              tx_done,
    output logic              irq
);
    logic               ready, active, frame_end, load, take_data;
    logic [FRAME_W-1:0] ld_bits;
    logic [CNT_W-1:0]   ld_len;
    logic [DATA_W-1:0]  hold;

    txf_sequencer u_seq (
        .clk(clk), .rst(rst), .tick(baud_tick), .ready(ready), .active(active),
        .en(tx_en), .brk(brk_req), .tdre(tx_empty), .hold(hold),
        .load(load), .take_data(take_data), .ld_bits(ld_bits), .ld_len(ld_len)
    );

    txf_shifter u_shift (
        .clk(clk), .rst(rst), .tick(baud_tick), .load(load),
        .ld_bits(ld_bits), .ld_len(ld_len),
        .txd(txd), .ready(ready), .active(active), .frame_end(frame_end)
    );

    txf_flags u_flags (
        .clk(clk), .rst(rst), .wr(dr_wr), .wdata(dr_wdata),
        .take_data(take_data), .load(load), .frame_end(frame_end),
        .ie_empty(ie_empty), .ie_done(ie_done),
        .hold(hold), .tdre(tx_empty), .tc(tx_done), .irq(irq)
    );
endmodule

// File: tb/async_tx_framer_test.sv
module async_tx_framer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b0, brk_req = 1'b0, dr_wr = 1'b0;
    logic [7:0] dr_wdata = 8'h00;
    logic       ie_empty = 1'b0, ie_done = 1'b0;
    logic       txd, tx_empty, tx_done, irq;

    int    n_checks = 0, n_fail = 0, cycles = 0, div = 0;
    string req = "R1";

    // reference model state
    int   q[$];
    bit   m_txd = 1, m_tdre = 1, m_tc = 0, m_irq = 0, m_act = 0;
    bit   m_enq = 0, m_brkq = 0, p_g = 0, p_b = 0, p_p = 0;
    bit [7:0] m_hold = 0;

    async_tx_framer uut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_en(tx_en), .brk_req(brk_req),
        .dr_wr(dr_wr), .dr_wdata(dr_wdata), .ie_empty(ie_empty), .ie_done(ie_done),
        .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (rst) begin div = 0; baud_tick <= 1'b0; end
        else begin div = (div + 1) % 4; baud_tick <= (div == 3); end
    end

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_txd = 1; m_tdre = 1; m_tc = 0; m_irq = 0; m_act = 0;
            m_enq = 0; m_brkq = 0; p_g = 0; p_b = 0; p_p = 0; m_hold = 0;
        end else begin
            bit nirq, old_act, loaded, ended;
            int kind; // 0 none, 1 guard, 2 break, 3 preamble, 4 data
            nirq = (ie_empty && m_tdre) || (ie_done && m_tc);
            old_act = m_act; loaded = 0; ended = 0; kind = 0;
            if (baud_tick) begin
                if (q.size() > 0) m_txd = q.pop_front();
                else begin
                    if (tx_en) begin
                        if (p_g) kind = 1;
                        else if (p_b) kind = 2;
                        else if (p_p) kind = 3;
                        else if (brk_req) kind = 2;
                        else if (!m_tdre) kind = 4;
                    end
                    if (kind == 1) q.push_back(1);
                    else if (kind == 2) for (int i = 0; i < 10; i++) q.push_back(0);
                    else if (kind == 3) for (int i = 0; i < 10; i++) q.push_back(1);
                    else if (kind == 4) begin
                        q.push_back(0);
                        for (int i = 0; i < 8; i++) q.push_back(int'(m_hold[i]));
                        q.push_back(1);
                    end
                    if (kind != 0) begin
                        loaded = 1; m_act = 1; m_txd = q.pop_front();
                    end else begin
                        ended = m_act; m_act = 0; m_txd = 1;
                    end
                end
            end
            if (kind == 4) m_tdre = 1;
            if (dr_wr) begin m_tdre = 0; m_hold = dr_wdata; end
            if (loaded) m_tc = 0; else if (ended) m_tc = 1;
            if (kind == 1) p_g = 0;
            if (kind == 2) p_b = 0;
            if (kind == 3) p_p = 0;
            if (tx_en && !m_enq) begin
                if (old_act) p_p = 1; else p_g = 1;
            end
            if (!brk_req && m_brkq) p_b = 1;
            m_enq = tx_en; m_brkq = brk_req;
            m_irq = nirq;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            n_checks++;
            if ({txd, tx_empty, tx_done, irq} !== {m_txd, m_tdre, m_tc, m_irq}) begin
                n_fail++;
                $display("FAIL %s cycle %0d: txd/empty/done/irq got %b%b%b%b exp %b%b%b%b",
                         req, cycles, txd, tx_empty, tx_done, irq, m_txd, m_tdre, m_tc, m_irq);
            end
        end
        if (cycles > 150000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(logic [7:0] d);
        @(negedge clk); dr_wr = 1'b1; dr_wdata = d;
        @(negedge clk); dr_wr = 1'b0;
    endtask

    task automatic wait_mid_frame();
        int guard = 0;
        @(negedge clk);
        while (!(m_act && q.size() > 4 && q.size() < 9) && guard < 2000) begin
            @(negedge clk); guard++;
        end
    endtask

    task automatic wait_empty();
        int guard = 0;
        while (!m_tdre && guard < 2000) begin @(negedge clk); guard++; end
    endtask

    initial begin
        wait_cyc(3);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1: explicit reset state
        n_checks++;
        if ({txd, tx_empty, tx_done, irq} !== 4'b1100) begin
            n_fail++;
            $display("FAIL R1: got %b%b%b%b exp 1100", txd, tx_empty, tx_done, irq);
        end
        wait_cyc(10);

        req = "R4"; tx_en = 1'b1; write_byte(8'hA5); wait_cyc(60);
        req = "R2"; write_byte(8'h3C); wait_cyc(2); wait_empty(); write_byte(8'h81); wait_cyc(100);
        req = "R11"; ie_empty = 1'b1; ie_done = 1'b1; write_byte(8'h5E); wait_cyc(60);
        req = "R9"; write_byte(8'hF0); write_byte(8'h0F); wait_cyc(100);
        req = "R5"; write_byte(8'h6B); wait_mid_frame();
        tx_en = 1'b0; wait_cyc(2); tx_en = 1'b1; write_byte(8'hC3); wait_cyc(120);
        req = "R3"; write_byte(8'h99); wait_mid_frame(); tx_en = 1'b0;
        write_byte(8'h12); wait_cyc(80); tx_en = 1'b1; wait_cyc(80);
        req = "R6"; ie_empty = 1'b0; write_byte(8'h77); brk_req = 1'b1; wait_cyc(100);
        req = "R7"; brk_req = 1'b0; wait_cyc(120);
        req = "R8"; write_byte(8'h24); wait_mid_frame();
        brk_req = 1'b1; tx_en = 1'b0; wait_cyc(1); brk_req = 1'b0; tx_en = 1'b1;
        write_byte(8'hE7); wait_cyc(150);
        req = "R10"; ie_done = 1'b1; write_byte(8'h01); wait_cyc(60);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule